// File: doc/BRIEF.md
# Mu-law Two-Party Conference Summer

This block adds two mu-law coded voice samples and returns their sum as a mu-law byte. It does the job of a conference bridge that mixes two talkers in the digital domain. A plain binary adder cannot work on companded bytes, so the block takes each operand through three steps. It expands the operand to a 14-bit signed linear value. It adds the two linear values in a 15-bit adder that cannot overflow. It then compresses the result back to an 8-bit code. Sums beyond the largest representable magnitude are clamped and never wrap.

One operand pair is accepted on any clock cycle where the shared valid is high. Results come out two cycles later with their own valid, so the block streams one sample pair per cycle. The whole function is the same as a table with 65536 entries indexed by the operand pair, but the table is computed in logic instead of being stored.

Top module: `mulaw_conf_adder`

## Requirements
- R1: Each operand byte carries the sign in bit 7 (1 = negative), a 3-bit segment E in bits 6:4 and a 4-bit step M in bits 3:0. The byte stands for the linear value (1-2S)*(2^E*(2M+33)-33), so magnitudes run from 0 to 8031.
- R2: The two linear values are added exactly in 15-bit signed arithmetic. A sum inside the code range is never altered by wrap-around.
- R3: The output code has the sign of the sum. Its magnitude field is the code whose decoded magnitude is the largest one not above the sum's magnitude, so rounding is toward zero.
- R4: A sum with magnitude above 8031 gives 8'h7F when positive and 8'hFF when negative.
- R5: A result whose decoded magnitude is zero is always 8'h00 (sign clear). This includes operands of equal magnitude and opposite sign, and a negative sum of magnitude 1.
- R6: out_vld is in_vld delayed by exactly two clock cycles. out_code is the result for the operands presented with that in_vld. A new pair may be accepted every cycle.
- R7: Swapping op_a and op_b does not change the result.
- R8: While rst is high, and on the first cycle after it falls, out_vld is 0 and out_code is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair on op_a/op_b is valid this cycle |
| op_a | input | 8 | First mu-law operand |
| op_b | input | 8 | Second mu-law operand |
| out_vld | output | 1 | out_code holds a result |
| out_code | output | 8 | Mu-law coded sum |

## Verification
A pair driven before rising edge k is decoded and summed into the first register at edge k. Its code reaches the output register at edge k+1. The bench drives inputs on falling edges and keeps a three-entry queue of expected results. On each falling edge it compares the outputs with the entry queued two falling edges earlier, and then queues the new expectation. Valid is checked on every cycle, including idle ones. The code is checked only when a result is expected, and each expectation comes from a brute-force search over all 128 code magnitudes.

// File: rtl/mulaw_conf_adder.sv
module mulaw_conf_adder #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [CODE_W-1:0] op_a,
  input  logic [CODE_W-1:0] op_b,
  output logic              out_vld,
  output logic [CODE_W-1:0] out_code
);

  localparam int LIN_W   = 14;
  localparam int SUM_W   = LIN_W + 1;
  localparam int BIAS    = 33;
  localparam int SEGS    = 8;
  localparam int MAX_MAG = ((2 * 15 + BIAS) << (SEGS - 1)) - BIAS;

  function automatic logic signed [LIN_W-1:0] expand(input logic [CODE_W-1:0] c);
    logic [LIN_W-1:0] seg_base;
    logic [LIN_W-1:0] mag;
    seg_base = {9'd0, c[3:0], 1'b0} + LIN_W'(BIAS);
    mag      = (seg_base << c[6:4]) - LIN_W'(BIAS);
    return c[7] ? -$signed(mag) : $signed(mag);
  endfunction

  logic signed [LIN_W-1:0] lin_a, lin_b;
  logic signed [SUM_W-1:0] lin_sum;

  assign lin_a   = expand(op_a);
  assign lin_b   = expand(op_b);
  assign lin_sum = $signed({lin_a[LIN_W-1], lin_a}) + $signed({lin_b[LIN_W-1], lin_b});

  logic                    s1_vld;
  logic signed [SUM_W-1:0] s1_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_sum <= '0;
    end else begin
      s1_vld <= in_vld;
      s1_sum <= lin_sum;
    end
  end

  logic [SUM_W-1:0]  abs_sum, biased, shifted, step;
  logic [2:0]        seg;
  logic [3:0]        mant;
  logic              sat;
  logic [CODE_W-2:0] code_mag;
  logic [CODE_W-1:0] enc;

  assign abs_sum = s1_sum[SUM_W-1] ? SUM_W'(-s1_sum) : SUM_W'(s1_sum);
  assign biased  = abs_sum + SUM_W'(BIAS);

  always_comb begin
    seg = 3'd0;
    for (int e = 1; e < SEGS; e++)
      if (biased >= SUM_W'(BIAS << e)) seg = 3'(e);
  end

  assign shifted  = biased >> seg;
  assign step     = (shifted - SUM_W'(BIAS)) >> 1;
  assign mant     = (step > SUM_W'(15)) ? 4'hF : step[3:0];
  assign sat      = abs_sum > SUM_W'(MAX_MAG);
  assign code_mag = sat ? '1 : {seg, mant};
  assign enc      = (code_mag == '0) ? '0 : {s1_sum[SUM_W-1], code_mag};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_code <= '0;
    end else begin
      out_vld  <= s1_vld;
      out_code <= enc;
    end
  end

  // R6
  vld_stage1_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> s1_vld);
  // R6
  idle_stage1_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !s1_vld);
  // R6
  vld_out_chk: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> out_vld);
  // R4
  sat_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_sum > SUM_W'(MAX_MAG)) |=> (out_code == 8'h7F));
  // R4
  sat_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_sum < -SUM_W'(MAX_MAG)) |=> (out_code == 8'hFF));
  // R3
  pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_sum[SUM_W-1]) |=> !out_code[7]);
  // R5
  zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_code[6:0] == 7'd0) |-> !out_code[7]);

endmodule

// File: tb/mulaw_conf_adder_bench.sv
`timescale 1ns/1ps
module mulaw_conf_adder_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_vld;
  logic [7:0] op_a, op_b;
  logic       out_vld;
  logic [7:0] out_code;

  always #2 clk = ~clk;

  mulaw_conf_adder u_mulaw_conf_adder (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(out_vld), .out_code(out_code)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       exp_v[3];
  logic [7:0] exp_c[3];
  string      exp_t[3];

  function automatic int code_mag(input int k);
    return ((2 * (k % 16) + 33) << (k / 16)) - 33;
  endfunction

  function automatic int decode(input logic [7:0] c);
    int m;
    m = code_mag(int'(c[6:0]));
    return c[7] ? -m : m;
  endfunction

  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b);
    int s, m, best;
    s = decode(a) + decode(b);
    m = (s < 0) ? -s : s;
    best = 0;
    for (int k = 0; k < 128; k++)
      if (code_mag(k) <= m) best = k;
    if (best == 0) return 8'h00;
    return (s < 0) ? (8'h80 | 8'(best)) : 8'(best);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic cycle(input logic v, input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    check(out_vld === exp_v[1], "R6", int'(out_vld), int'(exp_v[1]));
    if (exp_v[1])
      check(out_code === exp_c[1], exp_t[1], int'(out_code), int'(exp_c[1]));
    exp_v[2] = exp_v[1]; exp_c[2] = exp_c[1]; exp_t[2] = exp_t[1];
    exp_v[1] = exp_v[0]; exp_c[1] = exp_c[0]; exp_t[1] = exp_t[0];
    in_vld = v; op_a = a; op_b = b;
    exp_v[0] = v; exp_c[0] = model(a, b); exp_t[0] = tag;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin exp_v[i] = 1'b0; exp_c[i] = 8'h00; exp_t[i] = "R6"; end
    rst = 1'b1; in_vld = 1'b0; op_a = 8'h00; op_b = 8'h00;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(out_vld === 1'b0 && out_code === 8'h00, "R8", int'({out_vld, out_code}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_vld === 1'b0 && out_code === 8'h00, "R8", int'({out_vld, out_code}), 0);

    cycle(1'b1, 8'h25, 8'h00, "R1");
    cycle(1'b1, 8'hA5, 8'h80, "R1");
    cycle(1'b1, 8'h6F, 8'h6F, "R2");
    cycle(1'b1, 8'hEF, 8'hEF, "R2");
    cycle(1'b1, 8'h10, 8'h81, "R3");
    cycle(1'b1, 8'h90, 8'h01, "R3");
    cycle(1'b1, 8'h7F, 8'h7F, "R4");
    cycle(1'b1, 8'hFF, 8'hF0, "R4");
    cycle(1'b0, 8'h7F, 8'h7F, "R6");
    cycle(1'b1, 8'h7F, 8'hFF, "R5");
    cycle(1'b1, 8'h80, 8'h00, "R5");
    cycle(1'b1, 8'h3A, 8'hBA, "R5");
    cycle(1'b1, 8'h30, 8'hB3, "R5");
    cycle(1'b1, 8'h47, 8'h92, "R7");
    cycle(1'b1, 8'h92, 8'h47, "R7");

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a, b;
      logic v;
      a = 8'($urandom);
      b = 8'($urandom);
      v = ($urandom % 5) != 0;
      cycle(v, a, b, "R3");
      if (n % 7 == 0) cycle(1'b1, b, a, "R7");
    end
    repeat (3) cycle(1'b0, 8'h00, 8'h00, "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule